// File: doc/BRIEF.md
# Activity-Reloaded Idle Timer

This block watches one class of device, either a disk channel or the display controller, and tells the system when that device has gone unused for too long. Software programs a 16-bit idle period in seconds and sets an enable bit. From then on, a free-running one-second tick counts the period down. Any access to the watched device puts the full period back into the counter. If the counter runs out, the block raises a system management interrupt request. It also sets two sticky status bits: a top-level bit and a bit for this source.

Activity comes from two places. The first is a monitor on the system bus that sees every cycle's address and whether the cycle is I/O or memory. The second is an external activity strobe. The device class is chosen when the block is elaborated. A disk-channel instance reacts to I/O cycles on its one data port, which is either the primary or the secondary one. A display instance reacts to the legacy display I/O ranges and to the legacy display memory window. A small register bus gives software access to the period, the enable bit, the status bits and the live count.

Top module: `idle_timer`

## Requirements
- R1: After reset, the period register, the enable bit, both status bits and the count all read 0, and `smi_req` is low.
- R2: The register bus uses these offsets: 0 is the period (read/write, 16 bits); 1 is control, with bit 0 as the enable; 2 is status, with bit 0 as the top-level bit and bit 1 as the per-source bit; 3 is the live count (read only). Writes take effect on the clock edge. Reads are combinational.
- R3: While the block is enabled and no activity is present, each cycle with `sec_tick` high lowers a nonzero count by exactly 1. Cycles without a tick leave the count unchanged.
- R4: Any activity in a cycle loads the programmed period into the count at the next edge. A high `act_strobe` always counts as activity, for both device classes.
- R5: A disk instance treats only a valid I/O cycle to exactly its configured data port as bus activity. The primary port is 0x01F0 and the secondary port is 0x0170. The other port, memory cycles and other addresses have no effect.
- R6: A display instance treats as bus activity a valid I/O cycle to 0x3B0–0x3DF, or a valid memory cycle to 0xA0000–0xB7FFF. Addresses outside these ranges, cycles of the other type, and cycles without `bus_valid` have no effect.
- R7: A tick that takes the count from 1 to 0 sets both status bits and raises `smi_req`. The count then stays at 0 under further ticks until activity reloads it.
- R8: Writing 1 to a status bit clears it. `smi_req` is high while either status bit is set. If an expiry and a clear fall in the same cycle, the expiry wins.
- R9: While the enable bit is 0, the count follows the period register, ticks have no effect, and no interrupt is raised.
- R10: Once the count has been loaded from a period of 0, ticks never raise the interrupt.
- R11: When activity and a tick fall in the same cycle, the reload wins. The count returns to the full period and no expiry occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | CNT_W | Register write data |
| reg_rdata | output | CNT_W | Register read data |
| bus_valid | input | 1 | Monitored bus cycle present |
| bus_is_io | input | 1 | 1 for an I/O cycle, 0 for a memory cycle |
| bus_addr | input | ADDR_W | Address of the monitored cycle |
| act_strobe | input | 1 | External activity strobe |
| sec_tick | input | 1 | One-second timebase pulse |
| smi_req | output | 1 | Interrupt request |

## Verification
On every cycle, the embedded assertions check how the counter steps. They confirm a reload on activity or while disabled, a decrement of exactly one on a tick, a held count when there is no tick, and that both status bits are set after an expiry and that a status bit is cleared by a write of 1. The address decode cannot be checked this way. The directed scenarios show it, using boundary addresses on both sides of each range, the wrong cycle type, and the other disk port. The scenarios also cover the set-over-clear collision, the zero period, disabled operation, and the collision of a tick with a reload, all observed through the register read port and the interrupt pin.

// File: rtl/idle_tmr_pkg.sv
package idle_tmr_pkg;
   typedef enum logic [1:0] {
      DEV_DISK_PRI = 2'd0,
      DEV_DISK_SEC = 2'd1,
      DEV_DISPLAY  = 2'd2
   } dev_kind_e;

   localparam logic [1:0] OFS_PERIOD = 2'd0;
   localparam logic [1:0] OFS_CTRL   = 2'd1;
   localparam logic [1:0] OFS_STAT   = 2'd2;
   localparam logic [1:0] OFS_COUNT  = 2'd3;

   localparam logic [15:0] DISK_PRI_PORT = 16'h01F0;
   localparam logic [15:0] DISK_SEC_PORT = 16'h0170;
   localparam logic [31:0] DISP_MEM_LO   = 32'h000A_0000;
   localparam logic [31:0] DISP_MEM_HI   = 32'h000B_7FFF;
endpackage

// File: rtl/idle_act_decode.sv
module idle_act_decode
   import idle_tmr_pkg::*;
#(
   parameter int        ADDR_W = 20,
   parameter dev_kind_e KIND   = DEV_DISPLAY
) (
   input  logic              bus_valid,
   input  logic              bus_is_io,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              act_strobe,
   output logic              activity
);
   localparam logic [ADDR_W-1:0] MEM_LO = ADDR_W'(DISP_MEM_LO);
   localparam logic [ADDR_W-1:0] MEM_HI = ADDR_W'(DISP_MEM_HI);

   initial begin
      assert (ADDR_W >= 20) else $error("idle_act_decode: ADDR_W must be at least 20");
   end

   logic io_cyc;
   logic bus_hit;

   // I/O space is 16 bits wide; upper address bits must be clear
   assign io_cyc = bus_valid && bus_is_io && (bus_addr[ADDR_W-1:16] == '0);

   generate
      if (KIND == DEV_DISPLAY) begin : g_display
         logic io_win;
         logic mem_win;
         assign io_win  = io_cyc && ((bus_addr[15:4] == 12'h03B) ||
                                     (bus_addr[15:4] == 12'h03C) ||
                                     (bus_addr[15:4] == 12'h03D));
         assign mem_win = bus_valid && !bus_is_io &&
                          (bus_addr >= MEM_LO) && (bus_addr <= MEM_HI);
         assign bus_hit = io_win || mem_win;
      end else begin : g_disk
         localparam logic [15:0] PORT = (KIND == DEV_DISK_SEC) ? DISK_SEC_PORT : DISK_PRI_PORT;
         assign bus_hit = io_cyc && (bus_addr[15:0] == PORT);
      end
   endgenerate

   assign activity = bus_hit || act_strobe;
endmodule

// File: rtl/idle_countdown.sv
module idle_countdown #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             activity,
   input  logic             tick,
   input  logic [CNT_W-1:0] period,
   output logic [CNT_W-1:0] count,
   output logic             expire
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   initial begin
      assert (CNT_W >= 2) else $error("idle_countdown: CNT_W must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else if (!enable || activity) begin
         count <= period;
      end else if (tick && (count != '0)) begin
         count <= count - ONE;
      end
   end

   assign expire = enable && !activity && tick && (count == ONE);

   assert_reload_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && activity) |=> (count == $past(period)));

   assert_disabled_tracks_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable) |=> (count == $past(period)));

   assert_tick_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !activity && tick && (count != '0)) |=> (count == $past(count) - ONE));

   assert_no_tick_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !activity && !tick) |=> $stable(count));
endmodule

// File: rtl/idle_status.sv
module idle_status (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       expire,
   input  logic [1:0] clr,
   output logic       top_sts,
   output logic       src_sts
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         top_sts <= 1'b0;
         src_sts <= 1'b0;
      end else begin
         top_sts <= expire || (top_sts && !clr[0]);
         src_sts <= expire || (src_sts && !clr[1]);
      end
   end

   assert_expire_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> (top_sts && src_sts));

   assert_top_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (top_sts && clr[0] && !expire) |=> !top_sts);

   assert_src_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (src_sts && clr[1] && !expire) |=> !src_sts);

   assert_top_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(top_sts) |-> $past(clr[0]));
endmodule

// File: rtl/idle_timer.sv
module idle_timer
   import idle_tmr_pkg::*;
#(
   parameter int        CNT_W  = 16,
   parameter int        ADDR_W = 20,
   parameter dev_kind_e KIND   = DEV_DISPLAY
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [1:0]        reg_addr,
   input  logic [CNT_W-1:0]  reg_wdata,
   output logic [CNT_W-1:0]  reg_rdata,
   input  logic              bus_valid,
   input  logic              bus_is_io,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              act_strobe,
   input  logic              sec_tick,
   output logic              smi_req
);
   logic [CNT_W-1:0] period_q;
   logic             en_q;
   logic [CNT_W-1:0] count;
   logic             activity;
   logic             expire;
   logic             top_sts;
   logic             src_sts;
   logic [1:0]       clr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         period_q <= '0;
         en_q     <= 1'b0;
      end else if (reg_we) begin
         if (reg_addr == OFS_PERIOD) period_q <= reg_wdata;
         if (reg_addr == OFS_CTRL)   en_q     <= reg_wdata[0];
      end
   end

   assign clr = (reg_we && (reg_addr == OFS_STAT)) ? reg_wdata[1:0] : 2'b00;

   always_comb begin
      unique case (reg_addr)
         OFS_PERIOD: reg_rdata = period_q;
         OFS_CTRL:   reg_rdata = CNT_W'(en_q);
         OFS_STAT:   reg_rdata = CNT_W'({src_sts, top_sts});
         default:    reg_rdata = count;
      endcase
   end

   idle_act_decode #(.ADDR_W(ADDR_W), .KIND(KIND)) u_decode (
      .bus_valid (bus_valid),
      .bus_is_io (bus_is_io),
      .bus_addr  (bus_addr),
      .act_strobe(act_strobe),
      .activity  (activity)
   );

   idle_countdown #(.CNT_W(CNT_W)) u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (en_q),
      .activity(activity),
      .tick    (sec_tick),
      .period  (period_q),
      .count   (count),
      .expire  (expire)
   );

   idle_status u_status (
      .clk    (clk),
      .rst_n  (rst_n),
      .expire (expire),
      .clr    (clr),
      .top_sts(top_sts),
      .src_sts(src_sts)
   );

   assign smi_req = top_sts || src_sts;

   assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !smi_req) |=> !smi_req);
endmodule

// File: tb/test_idle_timer.sv
module test_idle_timer;
   import idle_tmr_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_is_io = 1'b0;
   logic [19:0] bus_addr = '0;
   logic        act_strobe = 1'b0;
   logic        sec_tick = 1'b0;

   logic        d_we = 1'b0;
   logic [1:0]  d_addr = 2'd0;
   logic [15:0] d_wdata = '0;
   logic [15:0] d_rdata;
   logic        d_irq;

   logic        k_we = 1'b0;
   logic [1:0]  k_addr = 2'd0;
   logic [15:0] k_wdata = '0;
   logic [15:0] k_rdata;
   logic        k_irq;

   int n_cmp = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   idle_timer #(.CNT_W(16), .ADDR_W(20), .KIND(DEV_DISPLAY)) i_idle_timer (
      .clk(clk), .rst_n(rst_n), .reg_we(d_we), .reg_addr(d_addr),
      .reg_wdata(d_wdata), .reg_rdata(d_rdata), .bus_valid(bus_valid),
      .bus_is_io(bus_is_io), .bus_addr(bus_addr), .act_strobe(act_strobe),
      .sec_tick(sec_tick), .smi_req(d_irq)
   );

   idle_timer #(.CNT_W(16), .ADDR_W(20), .KIND(DEV_DISK_PRI)) i_idle_timer_disk (
      .clk(clk), .rst_n(rst_n), .reg_we(k_we), .reg_addr(k_addr),
      .reg_wdata(k_wdata), .reg_rdata(k_rdata), .bus_valid(bus_valid),
      .bus_is_io(bus_is_io), .bus_addr(bus_addr), .act_strobe(act_strobe),
      .sec_tick(sec_tick), .smi_req(k_irq)
   );

   task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr_d(input logic [1:0] a, input logic [15:0] v);
      d_we = 1'b1; d_addr = a; d_wdata = v;
      step();
      d_we = 1'b0;
   endtask

   task automatic wr_k(input logic [1:0] a, input logic [15:0] v);
      k_we = 1'b1; k_addr = a; k_wdata = v;
      step();
      k_we = 1'b0;
   endtask

   task automatic rd_d(input logic [1:0] a, output logic [15:0] v);
      d_addr = a; #1; v = d_rdata;
   endtask

   task automatic rd_k(input logic [1:0] a, output logic [15:0] v);
      k_addr = a; #1; v = k_rdata;
   endtask

   task automatic tick();
      sec_tick = 1'b1; step(); sec_tick = 1'b0;
   endtask

   task automatic strobe();
      act_strobe = 1'b1; step(); act_strobe = 1'b0;
   endtask

   task automatic cyc(input logic io, input logic [19:0] a, input logic vld);
      bus_valid = vld; bus_is_io = io; bus_addr = a;
      step();
      bus_valid = 1'b0;
   endtask

   task automatic t_reset();
      logic [15:0] v;
      rd_d(OFS_PERIOD, v); chk("R1 period", v, 16'h0);
      rd_d(OFS_CTRL, v);   chk("R1 ctrl", v, 16'h0);
      rd_d(OFS_STAT, v);   chk("R1 status", v, 16'h0);
      rd_d(OFS_COUNT, v);  chk("R1 count", v, 16'h0);
      chk("R1 irq", {15'h0, d_irq}, 16'h0);
   endtask

   task automatic t_expiry();
      logic [15:0] v;
      wr_d(OFS_PERIOD, 16'd3);
      wr_d(OFS_CTRL, 16'd1);
      rd_d(OFS_PERIOD, v); chk("R2 period readback", v, 16'd3);
      rd_d(OFS_CTRL, v);   chk("R2 enable readback", v, 16'd1);
      rd_d(OFS_COUNT, v);  chk("R2 count loaded", v, 16'd3);
      tick(); tick();
      rd_d(OFS_COUNT, v);  chk("R3 two ticks", v, 16'd1);
      chk("R3 no irq yet", {15'h0, d_irq}, 16'h0);
      step();
      rd_d(OFS_COUNT, v);  chk("R3 no tick hold", v, 16'd1);
      tick();
      rd_d(OFS_COUNT, v);  chk("R7 count zero", v, 16'd0);
      rd_d(OFS_STAT, v);   chk("R7 both status", v, 16'd3);
      chk("R7 irq", {15'h0, d_irq}, 16'h1);
      tick();
      rd_d(OFS_COUNT, v);  chk("R7 stays zero", v, 16'd0);
   endtask

   task automatic t_clear();
      logic [15:0] v;
      wr_d(OFS_STAT, 16'd1);
      rd_d(OFS_STAT, v);   chk("R8 top cleared", v, 16'd2);
      chk("R8 irq while src set", {15'h0, d_irq}, 16'h1);
      wr_d(OFS_STAT, 16'd2);
      rd_d(OFS_STAT, v);   chk("R8 all cleared", v, 16'd0);
      chk("R8 irq dropped", {15'h0, d_irq}, 16'h0);
      strobe(); tick(); tick();
      d_we = 1'b1; d_addr = OFS_STAT; d_wdata = 16'd3; sec_tick = 1'b1;
      step();
      d_we = 1'b0; sec_tick = 1'b0;
      rd_d(OFS_STAT, v);   chk("R8 set beats clear", v, 16'd3);
      wr_d(OFS_STAT, 16'd3);
   endtask

   task automatic t_display();
      logic [15:0] v;
      strobe();
      rd_d(OFS_COUNT, v);  chk("R4 strobe reload", v, 16'd3);
      tick();
      cyc(1'b1, 20'h003C5, 1'b1);
      rd_d(OFS_COUNT, v);  chk("R6 io 3C5", v, 16'd3);
      tick();
      cyc(1'b1, 20'h003E0, 1'b1);
      rd_d(OFS_COUNT, v);  chk("R6 io 3E0 ignored", v, 16'd2);
      cyc(1'b1, 20'h003AF, 1'b1);
      rd_d(OFS_COUNT, v);  chk("R6 io 3AF ignored", v, 16'd2);
      cyc(1'b0, 20'hB7FFF, 1'b1);
      rd_d(OFS_COUNT, v);  chk("R6 mem B7FFF", v, 16'd3);
      tick();
      cyc(1'b0, 20'hB8000, 1'b1);
      rd_d(OFS_COUNT, v);  chk("R6 mem B8000 ignored", v, 16'd2);
      cyc(1'b0, 20'hA0000, 1'b1);
      rd_d(OFS_COUNT, v);  chk("R6 mem A0000", v, 16'd3);
      tick();
      cyc(1'b1, 20'hA0000, 1'b1);
      rd_d(OFS_COUNT, v);  chk("R6 io cycle to mem window", v, 16'd2);
      cyc(1'b0, 20'h003C5, 1'b1);
      rd_d(OFS_COUNT, v);  chk("R6 mem cycle to io port", v, 16'd2);
      cyc(1'b1, 20'h003C5, 1'b0);
      rd_d(OFS_COUNT, v);  chk("R6 no valid", v, 16'd2);
   endtask

   task automatic t_collide();
      logic [15:0] v;
      tick();
      rd_d(OFS_COUNT, v);  chk("R11 setup", v, 16'd1);
      sec_tick = 1'b1; act_strobe = 1'b1;
      step();
      sec_tick = 1'b0; act_strobe = 1'b0;
      rd_d(OFS_COUNT, v);  chk("R11 reload wins", v, 16'd3);
      rd_d(OFS_STAT, v);   chk("R11 no expiry", v, 16'd0);
   endtask

   task automatic t_disabled();
      logic [15:0] v;
      wr_d(OFS_CTRL, 16'd0);
      tick(); tick(); tick(); tick();
      rd_d(OFS_COUNT, v);  chk("R9 ticks ignored", v, 16'd3);
      chk("R9 no irq", {15'h0, d_irq}, 16'h0);
      wr_d(OFS_PERIOD, 16'd5);
      step();
      rd_d(OFS_COUNT, v);  chk("R9 tracks period", v, 16'd5);
   endtask

   task automatic t_zero();
      logic [15:0] v;
      wr_d(OFS_PERIOD, 16'd0);
      wr_d(OFS_CTRL, 16'd1);
      tick(); tick(); tick();
      rd_d(OFS_COUNT, v);  chk("R10 count zero", v, 16'd0);
      rd_d(OFS_STAT, v);   chk("R10 no status", v, 16'd0);
      chk("R10 no irq", {15'h0, d_irq}, 16'h0);
   endtask

   task automatic t_disk();
      logic [15:0] v;
      wr_k(OFS_PERIOD, 16'd2);
      wr_k(OFS_CTRL, 16'd1);
      tick();
      rd_k(OFS_COUNT, v);  chk("R5 setup", v, 16'd1);
      cyc(1'b1, 20'h00170, 1'b1);
      rd_k(OFS_COUNT, v);  chk("R5 other port ignored", v, 16'd1);
      cyc(1'b1, 20'h001F0, 1'b1);
      rd_k(OFS_COUNT, v);  chk("R5 data port reload", v, 16'd2);
      tick();
      cyc(1'b0, 20'h001F0, 1'b1);
      rd_k(OFS_COUNT, v);  chk("R5 memory cycle ignored", v, 16'd1);
      cyc(1'b1, 20'h003C5, 1'b1);
      rd_k(OFS_COUNT, v);  chk("R5 display port ignored", v, 16'd1);
      strobe();
      rd_k(OFS_COUNT, v);  chk("R4 disk strobe", v, 16'd2);
      tick(); tick();
      rd_k(OFS_STAT, v);   chk("R7 disk status", v, 16'd3);
      chk("R7 disk irq", {15'h0, k_irq}, 16'h1);
      chk("R10 display quiet", {15'h0, d_irq}, 16'h0);
   endtask

   initial begin
      #(20 * 100000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      step(); step();
      rst_n = 1'b1;
      step();
      t_reset();
      t_expiry();
      t_clear();
      t_display();
      t_collide();
      t_disabled();
      t_zero();
      t_disk();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule